// File: doc/BRIEF.md
# Transmit Descriptor Ring Poller

This block walks a circular list of 8-byte transmit descriptors held in memory. It reaches them through a simple single-outstanding word master port. While the transmitter is enabled, a poll reads the flags word of the current descriptor. If the controller owns that descriptor, the block fetches the buffer address and the length word, then hands one buffer request to a downstream byte-streaming engine. It then gives the descriptor back by writing the flags word with the ownership bit cleared, and advances the ring index.

A frame may span several descriptors. The block follows the chain until it meets the end-of-packet flag, then raises a one-cycle transmit-done pulse and polls the next descriptor at once, so back-to-back frames do not wait for the poll period. Polls come from a programmable down-counter, from a software demand pulse that preloads the counter, or from the completion of a frame. Each request carries:
- the FCS-append decision for the frame;
- a flag for a first buffer that is too short.

If a chained descriptor turns out not to be owned, the frame cannot continue and the transmitter enable is dropped.

Top module: `txring_poller`

## Requirements
- R1: After reset the transmitter enable and the demand flag read 0, and no memory access, buffer request or done pulse is active.
- R2: The descriptor at ring index i starts at byte address ring_base + 8*i. Its words sit at byte offsets 0 (low address), 2 (flags and high address) and 4 (length). A service reads offset 2 first, then 0, then 4. A memory access is held with a stable address until it is acknowledged.
- R3: A pulse on `txon_set` or `txon_clr` sets or clears the transmitter enable. A pulse on `tdmd_wr` sets the demand flag. Polls happen only while the enable is set, and each poll clears the demand flag.
- R4: A demand pulse that finds the demand flag clear makes a poll fire on the next cycle, whatever the poll period.
- R5: Without demand, polls recur every `poll_period`+1 cycles.
- R6: A poll that finds flags bit 15 (ownership) clear issues no request and no write, and leaves the ring index unchanged.
- R7: The request address is flags bits 7:0 placed above the 16-bit low-address word. The request length is the two's-complement negation of the length word. A request is held stable until it is accepted.
- R8: `req_fcs` is 1 when `dis_fcs` is 0, or when flags bit 13 of the frame's first descriptor is set. It is fixed for the whole frame.
- R9: `req_short` is 1 only on the first buffer of a frame, only when `int_loop` is 0, and only when the length is below 64 (flags bit 8 set in that first descriptor) or below 100 (bit 8 clear).
- R10: After a request is accepted, the flags word is written back to offset 2 with bit 15 cleared and every other bit kept. The index then advances modulo 2^`ring_log2`.
- R11: Descriptors are followed until one with flags bit 8 (end of packet) set. `req_first` marks the first buffer of the frame and `req_last` the end-of-packet buffer. `tx_int` pulses for one cycle after the final write-back.
- R12: After a frame completes, the next descriptor's flags word is acknowledged exactly 3 cycles after the `tx_int` pulse, without waiting for the poll period.
- R13: If a chained (non-first) descriptor is not owned, the transmitter enable clears and no `tx_int` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | ADDR_W | Byte address of descriptor 0 |
| ring_log2 | input | LOG2_W | Log2 of the number of descriptors |
| poll_period | input | PERIOD_W | Idle poll interval minus one, in cycles |
| txon_set | input | 1 | Pulse: enable transmitter |
| txon_clr | input | 1 | Pulse: disable transmitter |
| tdmd_wr | input | 1 | Pulse: transmit demand |
| dis_fcs | input | 1 | Mode: suppress FCS append |
| int_loop | input | 1 | Mode: internal loopback, no short-buffer flag |
| txon | output | 1 | Transmitter enable state |
| tdmd | output | 1 | Demand pending flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 16 | Read data |
| req_valid | output | 1 | Buffer request valid |
| req_ready | input | 1 | Engine accepts the request |
| req_addr | output | ADDR_W | Buffer byte address |
| req_len | output | 16 | Buffer length in bytes |
| req_first | output | 1 | First buffer of the frame |
| req_last | output | 1 | Last buffer of the frame |
| req_fcs | output | 1 | Append FCS to this frame |
| req_short | output | 1 | First buffer below the minimum length |
| tx_int | output | 1 | One-cycle frame-done pulse |

## Verification
The bench targets four timing points:
- the exact gap between idle polls (an off-by-one reload shows as 20 or 22 cycles instead of 21);
- the single-cycle response to a demand (a counter that was not preloaded would wait a full period);
- the immediate re-poll after a frame (a poller that waits for the period breaks the 3-cycle figure);
- ring wrap, where a missing modulo would fetch beyond the last descriptor.

It also covers the short-buffer thresholds in both the chained and the single-buffer case with loopback on and off, and the FCS decision under the mode bit and the per-frame override. A broken chain must drop the enable and leave both the done count and the poll count unchanged.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
    localparam int OWN_BIT    = 15;
    localparam int ADDFCS_BIT = 13;
    localparam int ENP_BIT    = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FLAGS,
        ST_RD_ADDR,
        ST_RD_LEN,
        ST_ISSUE,
        ST_WRITEBACK
    } walk_state_e;
endpackage

// File: rtl/tdr_poll_timer.sv
module tdr_poll_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                kick,
    input  logic [PERIOD_W-1:0] period,
    output logic                fire
);
    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        fire  = en && (tmr_q.cnt == '0);
        if (kick)
            tmr_d.cnt = '0;
        else if (fire)
            tmr_d.cnt = period;
        else if (en)
            tmr_d.cnt = tmr_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            tmr_q <= '0;
        else
            tmr_q <= tmr_d;
    end

    AST_KICK_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && en) |=> (fire || !en));  // R4
endmodule

// File: rtl/tdr_desc_walker.sv
module tdr_desc_walker
    import tdr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LOG2_W = 3,
    parameter int CMOS   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [LOG2_W-1:0] ring_log2,
    input  logic              txon_set,
    input  logic              txon_clr,
    input  logic              tdmd_wr,
    input  logic              dis_fcs,
    input  logic              int_loop,
    input  logic              fire,
    output logic              kick,
    output logic              txon,
    output logic              tdmd,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [15:0]       req_len,
    output logic              req_first,
    output logic              req_last,
    output logic              req_fcs,
    output logic              req_short,
    output logic              tx_int
);
    localparam int IDX_W = (1 << LOG2_W) - 1;
    localparam logic [15:0] MIN_SINGLE = 16'd64;
    localparam logic [15:0] MIN_CHAIN  = 16'd100;

    typedef struct packed {
        walk_state_e        st;
        logic [IDX_W-1:0]   idx;
        logic [15:0]        w_lo;
        logic [15:0]        w_flags;
        logic [15:0]        w_len;
        logic               in_chain;
        logic               fcs;
        logic               txon;
        logic               tdmd;
        logic               done;
    } walk_s;

    walk_s wk_d, wk_q;

    logic              override_ok;
    logic [IDX_W:0]    one_sh;
    logic [IDX_W-1:0]  idx_mask;
    logic [ADDR_W-1:0] desc_addr;
    logic              poll_take;
    logic [15:0]       min_len;

    generate
        if (CMOS != 0) begin : g_fcs_override
            assign override_ok = 1'b1;
        end else begin : g_fcs_fixed
            assign override_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        one_sh    = (IDX_W+1)'(1) << ring_log2;
        idx_mask  = IDX_W'(one_sh - 1'b1);
        desc_addr = ring_base + (ADDR_W'(wk_q.idx) << 3);
        poll_take = (wk_q.st == ST_IDLE) && fire && wk_q.txon;
        kick      = (tdmd_wr && !wk_q.tdmd) || wk_q.done;

        wk_d      = wk_q;
        wk_d.done = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = '0;
        req_valid = 1'b0;

        if (txon_set) wk_d.txon = 1'b1;
        if (txon_clr) wk_d.txon = 1'b0;
        if (poll_take) wk_d.tdmd = 1'b0;
        if (tdmd_wr) wk_d.tdmd = 1'b1;

        unique case (wk_q.st)
            ST_IDLE: begin
                if (poll_take) begin
                    wk_d.st       = ST_RD_FLAGS;
                    wk_d.in_chain = 1'b0;
                end
            end
            ST_RD_FLAGS: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'(2);
                if (mem_ack) begin
                    wk_d.w_flags = mem_rdata;
                    if (mem_rdata[OWN_BIT]) begin
                        wk_d.st = ST_RD_ADDR;
                        if (!wk_q.in_chain)
                            wk_d.fcs = !dis_fcs || (override_ok && mem_rdata[ADDFCS_BIT]);
                    end else begin
                        wk_d.st = ST_IDLE;
                        if (wk_q.in_chain)
                            wk_d.txon = 1'b0;
                    end
                end
            end
            ST_RD_ADDR: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr;
                if (mem_ack) begin
                    wk_d.w_lo = mem_rdata;
                    wk_d.st   = ST_RD_LEN;
                end
            end
            ST_RD_LEN: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'(4);
                if (mem_ack) begin
                    wk_d.w_len = mem_rdata;
                    wk_d.st    = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                req_valid = 1'b1;
                if (req_ready)
                    wk_d.st = ST_WRITEBACK;
            end
            ST_WRITEBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + ADDR_W'(2);
                mem_wdata = wk_q.w_flags & ~(16'd1 << OWN_BIT);
                if (mem_ack) begin
                    wk_d.idx = (wk_q.idx + 1'b1) & idx_mask;
                    if (wk_q.w_flags[ENP_BIT]) begin
                        wk_d.done = 1'b1;
                        wk_d.st   = ST_IDLE;
                    end else begin
                        wk_d.in_chain = 1'b1;
                        wk_d.st       = ST_RD_FLAGS;
                    end
                end
            end
            default: wk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_q    <= '0;
            wk_q.st <= ST_IDLE;
        end else begin
            wk_q <= wk_d;
        end
    end

    always_comb begin
        req_addr  = ADDR_W'({wk_q.w_flags[7:0], wk_q.w_lo});
        req_len   = ~wk_q.w_len + 16'd1;
        req_first = !wk_q.in_chain;
        req_last  = wk_q.w_flags[ENP_BIT];
        req_fcs   = wk_q.fcs;
        min_len   = wk_q.w_flags[ENP_BIT] ? MIN_SINGLE : MIN_CHAIN;
        req_short = !wk_q.in_chain && !int_loop && (req_len < min_len);
        txon      = wk_q.txon;
        tdmd      = wk_q.tdmd;
        tx_int    = wk_q.done;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)));  // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_int |=> !tx_int);  // R11
    AST_DEMAND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_take && !tdmd_wr) |=> !tdmd);  // R3
endmodule

// File: rtl/txring_poller.sv
module txring_poller #(
    parameter int ADDR_W       = 24,
    parameter int LOG2_W       = 3,
    parameter int PERIOD_W     = 16,
    parameter int CMOS_VARIANT = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   ring_base,
    input  logic [LOG2_W-1:0]   ring_log2,
    input  logic [PERIOD_W-1:0] poll_period,
    input  logic                txon_set,
    input  logic                txon_clr,
    input  logic                tdmd_wr,
    input  logic                dis_fcs,
    input  logic                int_loop,
    output logic                txon,
    output logic                tdmd,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [15:0]         mem_wdata,
    input  logic                mem_ack,
    input  logic [15:0]         mem_rdata,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [15:0]         req_len,
    output logic                req_first,
    output logic                req_last,
    output logic                req_fcs,
    output logic                req_short,
    output logic                tx_int
);
    logic poll_fire;
    logic poll_kick;

    tdr_poll_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (txon),
        .kick   (poll_kick),
        .period (poll_period),
        .fire   (poll_fire)
    );

    tdr_desc_walker #(
        .ADDR_W (ADDR_W),
        .LOG2_W (LOG2_W),
        .CMOS   (CMOS_VARIANT)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_base (ring_base),
        .ring_log2 (ring_log2),
        .txon_set  (txon_set),
        .txon_clr  (txon_clr),
        .tdmd_wr   (tdmd_wr),
        .dis_fcs   (dis_fcs),
        .int_loop  (int_loop),
        .fire      (poll_fire),
        .kick      (poll_kick),
        .txon      (txon),
        .tdmd      (tdmd),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_first (req_first),
        .req_last  (req_last),
        .req_fcs   (req_fcs),
        .req_short (req_short),
        .tx_int    (tx_int)
    );

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R2
endmodule

// File: tb/sim_txring_poller.sv
`timescale 1ns/1ps
module sim_txring_poller;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] ring_base = 24'h000040;
    logic [2:0]  ring_log2 = 3'd2;
    logic [15:0] poll_period = 16'd20;
    logic        txon_set = 1'b0, txon_clr = 1'b0, tdmd_wr = 1'b0;
    logic        dis_fcs = 1'b0, int_loop = 1'b0;
    logic        txon, tdmd, mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = 16'h0;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [23:0] req_addr;
    logic [15:0] req_len;
    logic        req_first, req_last, req_fcs, req_short, tx_int;

    always #2 clk = ~clk;

    txring_poller u0 (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_log2(ring_log2),
        .poll_period(poll_period), .txon_set(txon_set), .txon_clr(txon_clr),
        .tdmd_wr(tdmd_wr), .dis_fcs(dis_fcs), .int_loop(int_loop), .txon(txon),
        .tdmd(tdmd), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_first(req_first), .req_last(req_last),
        .req_fcs(req_fcs), .req_short(req_short), .tx_int(tx_int)
    );

    // memory model: 64 words, one-cycle acknowledge
    logic [15:0] mem [0:63];
    int cyc = 0;
    always @(posedge clk) begin
        cyc = cyc + 1;
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[6:1]] = mem_wdata;
            else        mem_rdata <= mem[mem_addr[6:1]];
        end
    end

    // event monitor, sampled mid-cycle
    int rd1_n = 0, rd1_cyc = 0, rd1_prev = 0;
    logic [23:0] rd1_addr = '0;
    int wr_n = 0;
    logic [23:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    int int_n = 0, int_cyc = 0;
    int rq_n = 0;
    logic [23:0] rq_addr [0:15];
    logic [15:0] rq_len [0:15];
    logic [3:0]  rq_flg [0:15];  // {first,last,fcs,short}
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_ack && !mem_we && mem_addr[2:0] == 3'd2) begin
                rd1_n = rd1_n + 1; rd1_prev = rd1_cyc; rd1_cyc = cyc; rd1_addr = mem_addr;
            end
            if (mem_req && mem_ack && mem_we) begin
                wr_n = wr_n + 1; wr_addr = mem_addr; wr_data = mem_wdata;
            end
            if (tx_int) begin int_n = int_n + 1; int_cyc = cyc; end
            if (req_valid && req_ready && rq_n < 16) begin
                rq_addr[rq_n] = req_addr; rq_len[rq_n] = req_len;
                rq_flg[rq_n] = {req_first, req_last, req_fcs, req_short};
                rq_n = rq_n + 1;
            end
        end
    end

    int checks = 0, errors = 0;
    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_set();   @(negedge clk) txon_set = 1'b1; @(negedge clk) txon_set = 1'b0; endtask
    task automatic pulse_clr();   @(negedge clk) txon_clr = 1'b1; @(negedge clk) txon_clr = 1'b0; endtask
    task automatic pulse_dmd();   @(negedge clk) tdmd_wr  = 1'b1; @(negedge clk) tdmd_wr  = 1'b0; endtask

    // descriptor k lives at byte 0x40 + 8k -> word 0x20 + 4k
    task automatic set_desc(input int k, input logic [15:0] lo, input logic [15:0] flags, input int len);
        mem[6'(32 + 4*k)]     = lo;
        mem[6'(32 + 4*k + 2)] = 16'(-len);
        mem[6'(32 + 4*k + 1)] = flags;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0;
        cycles(5);
        rst_n = 1'b1;
        cycles(2);
        // R1 reset state
        check("R1 txon", txon, 0);
        check("R1 tdmd", tdmd, 0);
        check("R1 mem_req", mem_req, 0);
        check("R1 req_valid", req_valid, 0);
        check("R1 tx_int", tx_int, 0);

        // R5/R6: idle polling of an unowned descriptor
        pulse_set();
        cycles(120);
        check("R3 polls while on", (rd1_n >= 4), 1);
        check("R5 poll spacing", rd1_cyc - rd1_prev, 21);
        check("R2 flags word address", rd1_addr, 24'h42);
        check("R6 no write", wr_n, 0);
        check("R6 no request", rq_n, 0);

        // R3: no polling while off, demand held
        begin
            int n;
            pulse_clr();
            cycles(5);
            n = rd1_n;
            pulse_dmd();
            cycles(60);
            check("R3 demand pending", tdmd, 1);
            check("R3 no poll while off", rd1_n, n);
            poll_period = 16'd1000;
            pulse_set();
            cycles(10);
            check("R3 poll on enable", rd1_n, n + 1);
            check("R3 demand cleared", tdmd, 0);
            // R4 demand response
            cycles(50);
            n = rd1_n;
            pulse_dmd();
            cycles(5);
            check("R4 demand poll", rd1_n, n + 1);
            check("R4 demand cleared", tdmd, 0);
        end

        // single-buffer frame in descriptor 0
        set_desc(0, 16'h1234, 16'h8105, 80);
        pulse_dmd();
        cycles(30);
        check("R7 addr", rq_addr[0], 24'h051234);
        check("R7 len", rq_len[0], 80);
        check("R11 first/last", rq_flg[0][3:2], 2'b11);
        check("R8 fcs default", rq_flg[0][1], 1);
        check("R9 single 80 not short", rq_flg[0][0], 0);
        check("R10 wb addr", wr_addr, 24'h42);
        check("R10 wb data", wr_data, 16'h0105);
        check("R11 done count", int_n, 1);
        check("R12 immediate repoll", rd1_cyc - int_cyc, 3);
        check("R10 index advanced", rd1_addr, 24'h4A);

        // chained frame in descriptors 1,2 with stalled engine
        dis_fcs = 1'b1;
        req_ready = 1'b0;
        set_desc(2, 16'h0200, 16'h8101, 30);
        set_desc(1, 16'h0100, 16'hA000, 50);
        pulse_dmd();
        cycles(20);
        check("R7 request held", req_valid, 1);
        check("R7 held addr", req_addr, 24'h000100);
        check("R7 nothing accepted", rq_n, 1);
        req_ready = 1'b1;
        cycles(40);
        check("R11 chain count", rq_n, 3);
        check("R7 chain len1", rq_len[1], 50);
        check("R9 chained 50 short", rq_flg[1], 4'b1011);
        check("R8 override fcs", rq_flg[2][1], 1);
        check("R11 second buffer flags", rq_flg[2], 4'b0110);
        check("R7 chain addr2", rq_addr[2], 24'h010200);
        check("R11 done after chain", int_n, 2);
        check("R10 last wb", wr_addr, 24'h52);
        check("R10 wb data keeps bits", wr_data, 16'h0101);

        // single short frame, no fcs, descriptor 3 then wrap
        set_desc(3, 16'hBEEF, 16'h8100, 40);
        pulse_dmd();
        cycles(30);
        check("R8 fcs off", rq_flg[3][1], 0);
        check("R9 single 40 short", rq_flg[3][0], 1);
        check("R7 len 40", rq_len[3], 40);
        check("R10 wrap", rd1_addr, 24'h42);
        check("R11 done 3", int_n, 3);

        // loopback short frame in descriptor 0
        int_loop = 1'b1; dis_fcs = 1'b0;
        set_desc(0, 16'h0010, 16'h8100, 10);
        pulse_dmd();
        cycles(30);
        check("R9 loopback not short", rq_flg[4][0], 0);
        check("R8 fcs on", rq_flg[4][1], 1);
        check("R7 len 10", rq_len[4], 10);
        check("R11 done 4", int_n, 4);

        // broken chain: descriptor 1 owned, 2 not
        int_loop = 1'b0;
        set_desc(2, 16'h0000, 16'h0001, 60);
        set_desc(1, 16'h0300, 16'h8000, 120);
        pulse_dmd();
        cycles(40);
        check("R13 one request", rq_n, 6);
        check("R9 chained 120 not short", rq_flg[5], 4'b1010);
        check("R13 txon dropped", txon, 0);
        check("R13 no done", int_n, 4);
        begin
            int n;
            n = rd1_n;
            pulse_dmd();
            cycles(40);
            check("R3 off after fault", rd1_n, n);
            check("R3 demand stays", tdmd, 1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule